// File: doc/BRIEF.md
# Ping-Pong Instruction Queue Refill Engine

This block keeps an on-chip instruction queue topped up from an instruction region held in external memory while a downstream consumer executes out of that same queue. The queue has two equal halves. After a start pulse, a fill state machine reads the region one half-sized chunk at a time. Each chunk goes into the half that the consumer is not executing, so it replaces code that has already run. Offsets inside the region count from zero. The memory address of every request is the latched region base plus that offset.

Each half has a ready flag. The flag is raised when the last instruction of its chunk has arrived. It is dropped when the consumer reads the last slot of that half. The consumer-side instruction pointer needs no enable. It delivers an instruction as soon as the half under it is ready, and it stalls on a half that is not ready. The final chunk may be shorter than a half, and the latched region length acts as the end pointer.

Fill states: `FS_IDLE` (waits for start), `FS_FETCH` (issues requests and collects responses for one chunk), `FS_WAIT_FREE` (the next target half still holds unexecuted code), `FS_DONE` (the region is fully streamed). Transitions:
- IDLE→FETCH on start with a non-zero length, and IDLE→DONE on start with zero length.
- FETCH→DONE when the last chunk completes.
- FETCH→WAIT_FREE when a chunk completes and the other half is still ready.
- FETCH→FETCH when a chunk completes and the other half is free.
- WAIT_FREE→FETCH when the target half is released.
- DONE→FETCH or DONE→DONE on a new start.

Top module: `iq_streamer`

## Requirements
- R1: After reset, `mem_req_valid_o`, `fetch_valid_o` and `prog_done_o` are all 0.
- R2: A start pulse accepted in idle or done latches base and length. The block then requests the addresses base+0, base+1, … in strictly increasing order, one per accepted handshake, and requests exactly length words in total. An address is held stable while its request waits for ready.
- R3: The block never holds more than two halves of unexecuted code. If the consumer never reads, exactly 2×HALF_DEPTH requests are issued, and no request is raised while both halves are ready.
- R4: `fetch_valid_o` stays 0 until every instruction of the chunk under the pointer has arrived. It rises one clock after the edge that takes that chunk's last response.
- R5: Instructions reach the consumer in region order, one per cycle in which `fetch_req_i` and `fetch_valid_o` are both 1. Each one equals the memory word at base+offset, and an overwritten or stale word is never returned.
- R6: When the consumer reads the last slot of a half, that half is released. If the fill engine is waiting on it, a new request is raised two clock edges after the consuming edge.
- R7: A final partial chunk delivers only the remaining words. `fetch_valid_o` stays 0 once the pointer equals the region length.
- R8: `prog_done_o` is 1 exactly when the region is fully streamed and fully consumed. While it is 1, no request is raised and no instruction is offered.
- R9: A start pulse while a region is streaming (fetch or wait) is ignored. Base, length and the delivered sequence are unchanged.
- R10: A start with length 0 raises `prog_done_o` one clock later and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse once the region is loaded |
| region_base_i | input | ADDR_W | Memory address of region offset 0 |
| region_len_i | input | LEN_W | Region length in instructions |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | ADDR_W | Read request address |
| mem_rsp_valid_i | input | 1 | Read data valid (in request order) |
| mem_rsp_data_i | input | INSTR_W | Read data |
| fetch_req_i | input | 1 | Consumer asks for the next instruction |
| fetch_valid_o | output | 1 | An instruction is available at the pointer |
| fetch_data_o | output | INSTR_W | Instruction at the pointer |
| prog_done_o | output | 1 | Region fully streamed and consumed |

## Verification
An instruction offer depends on a registered ready flag, so it appears one clock after the edge that takes the last response of its chunk. A release reaches the memory port two edges after the consuming edge, because the flag clears first and the fill state leaves its wait state on the following edge. A zero-length start shows done one edge after the start. The bench drives every input and samples every output at the falling edge. It records the falling-edge index of each response, each consumption and each request rise, and compares those indices against these offsets. Delivered words are compared against a scoreboard queue that the start task fills from the region contents.

// File: rtl/iqs_pkg.sv
package iqs_pkg;
    typedef enum logic [1:0] {
        FS_IDLE      = 2'd0,
        FS_FETCH     = 2'd1,
        FS_WAIT_FREE = 2'd2,
        FS_DONE      = 2'd3
    } fill_state_e;
endpackage

// File: rtl/iqs_queue_ram.sv
module iqs_queue_ram #(
    parameter int W     = 64,
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = store_q[rd_idx];
endmodule

// File: rtl/iqs_half_flags.sv
module iqs_half_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_all_i,
    input  logic       set_en_i,
    input  logic       set_sel_i,
    input  logic       rel_en_i,
    input  logic       rel_sel_i,
    output logic [1:0] ready_o
);
    for (genvar g = 0; g < 2; g++) begin : g_half
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ready_o[g] <= 1'b0;
            end else if (clr_all_i) begin
                ready_o[g] <= 1'b0;
            end else if (set_en_i && (set_sel_i == 1'(g))) begin
                ready_o[g] <= 1'b1;
            end else if (rel_en_i && (rel_sel_i == 1'(g))) begin
                ready_o[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/iqs_fill_ctrl.sv
module iqs_fill_ctrl
    import iqs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int HALF_DEPTH = 8,
    localparam int HB    = $clog2(HALF_DEPTH),
    localparam int IDX_W = HB + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              mem_req_ready_i,
    input  logic              mem_rsp_valid_i,
    input  logic [1:0]        half_ready_i,
    output logic              mem_req_valid_o,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic              set_en_o,
    output logic              set_sel_o,
    output logic              clr_all_o,
    output logic [LEN_W-1:0]  len_o,
    output fill_state_e       state_o
);
    localparam logic [LEN_W-1:0] HALF_L = LEN_W'(HALF_DEPTH);
    localparam logic [LEN_W-1:0] ONE_L  = LEN_W'(1);
    localparam logic [LEN_W-1:0] ZERO_L = '0;

    fill_state_e       state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cbase_q;
    logic [LEN_W-1:0]  req_q;
    logic [LEN_W-1:0]  rsp_q;

    logic [LEN_W-1:0]  remain;
    logic [LEN_W-1:0]  clen;
    logic [LEN_W-1:0]  cnext;
    logic [LEN_W-1:0]  req_off;
    logic [LEN_W-1:0]  wr_off;
    logic              tgt;
    logic              start_acc;
    logic              req_fire;
    logic              rsp_take;
    logic              rsp_last;

    assign remain    = len_q - cbase_q;
    assign clen      = (remain > HALF_L) ? HALF_L : remain;
    assign cnext     = cbase_q + clen;
    assign tgt       = cbase_q[HB];
    assign req_off   = cbase_q + req_q;
    assign wr_off    = cbase_q + rsp_q;
    assign start_acc = ((state_q == FS_IDLE) || (state_q == FS_DONE)) && start_i;
    assign req_fire  = mem_req_valid_o && mem_req_ready_i;
    assign rsp_take  = (state_q == FS_FETCH) && mem_rsp_valid_i;
    assign rsp_last  = rsp_take && ((rsp_q + ONE_L) == clen);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE, FS_DONE: begin
                if (start_i) begin
                    state_d = (len_i == ZERO_L) ? FS_DONE : FS_FETCH;
                end
            end
            FS_FETCH: begin
                if (rsp_last) begin
                    if (cnext >= len_q) begin
                        state_d = FS_DONE;
                    end else if (half_ready_i[~tgt]) begin
                        state_d = FS_WAIT_FREE;
                    end else begin
                        state_d = FS_FETCH;
                    end
                end
            end
            FS_WAIT_FREE: begin
                if (!half_ready_i[tgt]) begin
                    state_d = FS_FETCH;
                end
            end
        endcase
    end

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            base_q  <= '0;
            len_q   <= '0;
            cbase_q <= '0;
            req_q   <= '0;
            rsp_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_acc) begin
                base_q  <= base_i;
                len_q   <= len_i;
                cbase_q <= '0;
                req_q   <= '0;
                rsp_q   <= '0;
            end else if (state_q == FS_FETCH) begin
                if (rsp_last) begin
                    cbase_q <= cnext;
                    req_q   <= '0;
                    rsp_q   <= '0;
                end else begin
                    if (req_fire) begin
                        req_q <= req_q + ONE_L;
                    end
                    if (rsp_take) begin
                        rsp_q <= rsp_q + ONE_L;
                    end
                end
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req_valid_o = (state_q == FS_FETCH) && (req_q < clen);
        mem_req_addr_o  = base_q + ADDR_W'(req_off);
        wr_en_o         = rsp_take;
        wr_idx_o        = wr_off[IDX_W-1:0];
        set_en_o        = rsp_last;
        set_sel_o       = tgt;
        clr_all_o       = start_acc;
        len_o           = len_q;
        state_o         = state_q;
    end
endmodule

// File: rtl/iqs_read_port.sv
module iqs_read_port #(
    parameter int LEN_W      = 16,
    parameter int HALF_DEPTH = 8,
    localparam int HB    = $clog2(HALF_DEPTH),
    localparam int IDX_W = HB + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [1:0]       half_ready_i,
    input  logic             fetch_req_i,
    output logic             fetch_valid_o,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             rel_en_o,
    output logic             rel_sel_o,
    output logic [LEN_W-1:0] ptr_o
);
    localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

    logic [LEN_W-1:0] ptr_q;
    logic             take;

    assign fetch_valid_o = half_ready_i[ptr_q[HB]] && (ptr_q < len_i);
    assign take          = fetch_valid_o && fetch_req_i;
    assign rel_en_o      = take && (&ptr_q[HB-1:0]);
    assign rel_sel_o     = ptr_q[HB];
    assign rd_idx_o      = ptr_q[IDX_W-1:0];
    assign ptr_o         = ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (restart_i) begin
            ptr_q <= '0;
        end else if (take) begin
            ptr_q <= ptr_q + ONE_L;
        end
    end
endmodule

// File: rtl/iq_streamer.sv
module iq_streamer
    import iqs_pkg::*;
#(
    parameter int INSTR_W    = 64,
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int HALF_DEPTH = 8,
    localparam int DEPTH = 2 * HALF_DEPTH,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [ADDR_W-1:0]  region_base_i,
    input  logic [LEN_W-1:0]   region_len_i,
    output logic               mem_req_valid_o,
    input  logic               mem_req_ready_i,
    output logic [ADDR_W-1:0]  mem_req_addr_o,
    input  logic               mem_rsp_valid_i,
    input  logic [INSTR_W-1:0] mem_rsp_data_i,
    input  logic               fetch_req_i,
    output logic               fetch_valid_o,
    output logic [INSTR_W-1:0] fetch_data_o,
    output logic               prog_done_o
);
    logic [1:0]       half_ready;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             set_en;
    logic             set_sel;
    logic             clr_all;
    logic             rel_en;
    logic             rel_sel;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] rd_ptr;
    fill_state_e      fill_state;

    iqs_fill_ctrl #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .HALF_DEPTH(HALF_DEPTH)
    ) u_fill (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .base_i         (region_base_i),
        .len_i          (region_len_i),
        .mem_req_ready_i(mem_req_ready_i),
        .mem_rsp_valid_i(mem_rsp_valid_i),
        .half_ready_i   (half_ready),
        .mem_req_valid_o(mem_req_valid_o),
        .mem_req_addr_o (mem_req_addr_o),
        .wr_en_o        (wr_en),
        .wr_idx_o       (wr_idx),
        .set_en_o       (set_en),
        .set_sel_o      (set_sel),
        .clr_all_o      (clr_all),
        .len_o          (len_q),
        .state_o        (fill_state)
    );

    iqs_half_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all_i(clr_all),
        .set_en_i (set_en),
        .set_sel_i(set_sel),
        .rel_en_i (rel_en),
        .rel_sel_i(rel_sel),
        .ready_o  (half_ready)
    );

    iqs_queue_ram #(
        .W    (INSTR_W),
        .DEPTH(DEPTH)
    ) u_ram (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(mem_rsp_data_i),
        .rd_idx (rd_idx),
        .rd_data(fetch_data_o)
    );

    iqs_read_port #(
        .LEN_W     (LEN_W),
        .HALF_DEPTH(HALF_DEPTH)
    ) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_i    (clr_all),
        .len_i        (len_q),
        .half_ready_i (half_ready),
        .fetch_req_i  (fetch_req_i),
        .fetch_valid_o(fetch_valid_o),
        .rd_idx_o     (rd_idx),
        .rel_en_o     (rel_en),
        .rel_sel_o    (rel_sel),
        .ptr_o        (rd_ptr)
    );

    assign prog_done_o = (fill_state == FS_DONE) && (rd_ptr == len_q);
endmodule

// File: rtl/iqs_checker.sv
module iqs_checker
    import iqs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int HALF_DEPTH = 8,
    localparam int HB = $clog2(HALF_DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mem_req_valid_o,
    input logic              mem_req_ready_i,
    input logic [ADDR_W-1:0] mem_req_addr_o,
    input logic              fetch_req_i,
    input logic              fetch_valid_o,
    input logic              prog_done_o,
    input logic [1:0]        half_ready,
    input logic [LEN_W-1:0]  rd_ptr,
    input logic [LEN_W-1:0]  len_q,
    input fill_state_e       fill_state
);
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> !(&half_ready));

    // R4
    offer_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_o |-> half_ready[rd_ptr[HB]]);

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_o && fetch_req_i && !start_i) |=> (rd_ptr == $past(rd_ptr) + LEN_W'(1)));

    // R7
    end_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_o |-> (rd_ptr < len_q));

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done_o |-> (!mem_req_valid_o && !fetch_valid_o));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (fill_state == FS_FETCH || fill_state == FS_WAIT_FREE)) |=> (len_q == $past(len_q)));
endmodule

bind iq_streamer iqs_checker #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .HALF_DEPTH(HALF_DEPTH)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o (mem_req_addr_o),
    .fetch_req_i    (fetch_req_i),
    .fetch_valid_o  (fetch_valid_o),
    .prog_done_o    (prog_done_o),
    .half_ready     (half_ready),
    .rd_ptr         (rd_ptr),
    .len_q          (len_q),
    .fill_state     (fill_state)
);

// File: tb/iq_streamer_tb.sv
`timescale 1ns/1ps
module iq_streamer_tb;
    localparam int INSTR_W = 64;
    localparam int ADDR_W  = 32;
    localparam int LEN_W   = 16;
    localparam int HALF    = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [ADDR_W-1:0]  region_base_i = '0;
    logic [LEN_W-1:0]   region_len_i = '0;
    logic               mem_req_valid_o;
    logic               mem_req_ready_i = 1'b0;
    logic [ADDR_W-1:0]  mem_req_addr_o;
    logic               mem_rsp_valid_i = 1'b0;
    logic [INSTR_W-1:0] mem_rsp_data_i = '0;
    logic               fetch_req_i = 1'b0;
    logic               fetch_valid_o;
    logic [INSTR_W-1:0] fetch_data_o;
    logic               prog_done_o;

    always #2.5 clk = ~clk;

    iq_streamer #(
        .INSTR_W(INSTR_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .HALF_DEPTH(HALF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .region_base_i(region_base_i), .region_len_i(region_len_i),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
        .mem_rsp_data_i(mem_rsp_data_i), .fetch_req_i(fetch_req_i),
        .fetch_valid_o(fetch_valid_o), .fetch_data_o(fetch_data_o),
        .prog_done_o(prog_done_o)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int lat = 2;
    int rdy_mode = 0;
    int cons_mode = 0;
    int budget = 0;
    logic [ADDR_W-1:0] exp_base = '0;
    int req_seen = 0;
    int rsp_driven = 0;
    int chunk0_n = 0;
    int chunk0_cyc = -1;
    int first_valid_cyc = -1;
    int consumed = 0;
    int cons8_cyc = -1;
    int req_rise_cyc = -1;
    logic prev_req = 1'b0;
    logic [INSTR_W-1:0] sb_q[$];
    logic [ADDR_W-1:0] pq_addr[$];
    int pq_due[$];

    function automatic logic [INSTR_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return {a ^ 32'hA5C3_0F1E, ~a};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Memory model, consumer driver and scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            mem_req_ready_i = 1'b0;
            mem_rsp_valid_i = 1'b0;
            fetch_req_i     = 1'b0;
        end else begin
            mem_req_ready_i = (rdy_mode == 0) ? 1'b1 : (cyc % 3 == 0);
            if (mem_req_valid_o && !prev_req) req_rise_cyc = cyc;
            prev_req = mem_req_valid_o;
            if (mem_req_valid_o && mem_req_ready_i) begin
                // R2: addresses in order from the latched base
                chk(mem_req_addr_o == exp_base + ADDR_W'(req_seen), "R2 addr",
                    64'(mem_req_addr_o), 64'(exp_base + ADDR_W'(req_seen)));
                pq_addr.push_back(mem_req_addr_o);
                pq_due.push_back(cyc + lat);
                req_seen++;
            end
            if (pq_addr.size() > 0 && pq_due[0] <= cyc) begin
                mem_rsp_valid_i = 1'b1;
                mem_rsp_data_i  = mem_word(pq_addr.pop_front());
                void'(pq_due.pop_front());
                rsp_driven++;
                if (rsp_driven == chunk0_n) chunk0_cyc = cyc;
            end else begin
                mem_rsp_valid_i = 1'b0;
            end
            fetch_req_i = (cons_mode == 0) ? 1'b1 :
                          (cons_mode == 1) ? cyc[0] : (budget > 0);
            if (fetch_valid_o && first_valid_cyc < 0) first_valid_cyc = cyc;
            if (fetch_valid_o && fetch_req_i) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R5 extra word", 64'(fetch_data_o), 64'(0));
                end else begin
                    logic [INSTR_W-1:0] e;
                    e = sb_q.pop_front();
                    chk(fetch_data_o == e, "R5 data", fetch_data_o, e);
                end
                consumed++;
                if (consumed == HALF) cons8_cyc = cyc;
                if (cons_mode == 2) budget--;
            end
        end
    end

    task automatic launch(input logic [ADDR_W-1:0] base, input int len);
        @(posedge clk);
        exp_base = base;
        req_seen = 0;
        rsp_driven = 0;
        chunk0_n = (len < HALF) ? len : HALF;
        chunk0_cyc = -1;
        first_valid_cyc = -1;
        consumed = 0;
        cons8_cyc = -1;
        for (int i = 0; i < len; i++) sb_q.push_back(mem_word(base + ADDR_W'(i)));
        @(negedge clk);
        start_i = 1'b1;
        region_base_i = base;
        region_len_i = LEN_W'(len);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (!prog_done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(prog_done_o == 1'b1, tag, 64'(prog_done_o), 64'(1));
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(mem_req_valid_o == 1'b0, "R1 req", 64'(mem_req_valid_o), 64'(0));
        chk(fetch_valid_o == 1'b0, "R1 valid", 64'(fetch_valid_o), 64'(0));
        chk(prog_done_o == 1'b0, "R1 done", 64'(prog_done_o), 64'(0));

        // R10: empty region
        launch(32'h0000_0500, 0);
        chk(prog_done_o == 1'b1, "R10 done", 64'(prog_done_o), 64'(1));
        repeat (5) @(negedge clk);
        chk(req_seen == 0, "R10 no req", 64'(req_seen), 64'(0));

        // Main run: partial last chunk, fast memory, greedy consumer
        rdy_mode = 0; cons_mode = 0; lat = 2;
        launch(32'h0000_0100, 37);
        wait_done("R8 done main");
        // R4: offer appears one clock after the last response of chunk 0
        chk(first_valid_cyc == chunk0_cyc + 1, "R4 first offer",
            64'(first_valid_cyc), 64'(chunk0_cyc + 1));
        chk(req_seen == 37, "R2 req count", 64'(req_seen), 64'(37));
        // R7: nothing offered past the end
        chk(consumed == 37, "R7 count", 64'(consumed), 64'(37));
        chk(fetch_valid_o == 1'b0, "R7 valid low", 64'(fetch_valid_o), 64'(0));
        chk(sb_q.size() == 0, "R5 drained", 64'(sb_q.size()), 64'(0));

        // R9: start during streaming is ignored; slow ready, sparse consumer
        rdy_mode = 1; cons_mode = 1; lat = 4;
        launch(32'h0000_2000, 20);
        repeat (10) @(negedge clk);
        start_i = 1'b1; region_base_i = 32'h0000_9000; region_len_i = 16'd5;
        @(negedge clk);
        start_i = 1'b0;
        wait_done("R9 done");
        chk(consumed == 20, "R9 count", 64'(consumed), 64'(20));
        chk(req_seen == 20, "R9 req count", 64'(req_seen), 64'(20));
        chk(sb_q.size() == 0, "R9 drained", 64'(sb_q.size()), 64'(0));

        // R3 and R6: stalled consumer, then release one half
        rdy_mode = 0; cons_mode = 2; budget = 0; lat = 3;
        launch(32'h0000_0040, 30);
        repeat (120) @(negedge clk);
        chk(req_seen == 2 * HALF, "R3 two halves", 64'(req_seen), 64'(2 * HALF));
        chk(fetch_valid_o == 1'b1, "R3 offer", 64'(fetch_valid_o), 64'(1));
        @(posedge clk);
        budget = HALF;
        repeat (30) @(negedge clk);
        chk(consumed == HALF, "R6 consumed", 64'(consumed), 64'(HALF));
        chk(req_rise_cyc == cons8_cyc + 2, "R6 refill", 64'(req_rise_cyc), 64'(cons8_cyc + 2));
        @(posedge clk);
        cons_mode = 0;
        wait_done("R8 done stall");
        chk(consumed == 30, "R7 count stall", 64'(consumed), 64'(30));
        chk(req_seen == 30, "R2 req count stall", 64'(req_seen), 64'(30));

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule